// File: doc/BRIEF.md
# Banked Interrupt Controller

This block gathers a parameterised number of interrupt inputs (64 by default), organised as banks of 32, and turns them into two active-high requests for a processor: a normal request and a fast request. Each line has its own settings for enable, detection type (edge or level), polarity and routing. Software reaches them through a word-wide register bus with a combinational read path.

Each input is first synchronised by two flops. A level line is pending for as long as its polarity-corrected input is active. An edge line latches a sticky pending bit on its active edge, and only a clear write removes that bit. A software-interrupt bit can force any line pending. Software can read raw pending state before enable masking. It can also read the number of the lowest enabled pending normal line. A two-bit master enable gates each output on its own.

Top module: `irq_hub`

## Requirements
- R1: Line n sits in bank n/32 at bit n mod 32. A register family at base offset F holds bank b at byte address F + 4*b. The enable family (base 0x10) reads back the last value written to it, and a write to one bank leaves the other banks unchanged.
- R2: At base 0x30, a 1 bit sets that enable bit. At base 0x20, a 1 bit clears that enable bit. Bits written as 0 leave the enable unchanged.
- R3: The type family (base 0x40) selects detection, with 1 for edge and 0 for level. For a level line the raw status bit equals the input XOR the polarity bit (base 0x50, 1 = active-low). An input change shows in raw status two clocks after it is applied, and not after one.
- R4: For an edge line, the pending bit is set on a rising edge when the polarity bit is 0, and on a falling edge when the polarity bit is 1. The opposite edge does not set it. Once set, the bit holds after the input returns. Only a 1 written to the clear family (base 0xB0) removes it, and 0 bits leave it unchanged. A clear written to a level line has no effect.
- R5: When a clear write and a newly detected active edge on the same line fall in the same clock, the line stays pending.
- R6: The route family (base 0x00) sends a line to the fast output when its bit is 1 and to the normal output when it is 0. An output is high when at least one enabled, pending line routed to it exists and its master bit is set.
- R7: The master-enable register at 0x64 gates the outputs. Bit 0 gates the normal output and bit 1 gates the fast output.
- R8: The raw status family (base 0xA0) shows pending state whether or not the line is enabled.
- R9: A 1 in the software-interrupt family (base 0xC0) makes that line pending until software writes the bit back to 0. The family reads back as written.
- R10: Address 0xD0 returns the number of the lowest-numbered line that is enabled, pending and routed to the normal output. It returns 0xFFFFFFFF when no such line exists, and fast-routed lines are ignored.
- R11: After reset every register is zero and both outputs are low. Reads of unmapped offsets return zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_in | input | NUM_LINES | Asynchronous interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
The two functions that can land in the same clock are an acknowledge write to the clear family and the detection of a new active edge on the same line. The bench provokes this by raising an edge line's input and timing a clear write for that line so that the write is strobed on the exact edge where the synchroniser's edge detector fires. It then reads raw status and expects the line still pending, and a second clear with no new edge must then remove it.

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_in,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 irq_norm,
  output logic                 irq_fast
);
  localparam int NB = NUM_LINES / 32;

  logic [NUM_LINES-1:0] s1, s2, s3;
  logic [NUM_LINES-1:0] sel_q, en_q, typ_q, pol_q, swi_q, latch_q;
  logic [1:0]           master_q;
  logic [NUM_LINES-1:0] edge_hit, clr_vec, pend, nrm_hit, fst_hit;
  logic [31:0]          pend_num;

  wire       in_win = (addr[ADDR_W-1:8] == '0) && (addr[1:0] == 2'b00);
  wire [3:0] fam    = addr[7:4];
  wire [1:0] bank   = addr[3:2];

  assign edge_hit = typ_q & (s2 ^ s3) & (s2 ^ pol_q);
  assign pend     = (typ_q & latch_q) | (~typ_q & (s2 ^ pol_q)) | swi_q;
  assign nrm_hit  = pend & en_q & ~sel_q;
  assign fst_hit  = pend & en_q & sel_q;
  assign irq_norm = master_q[0] & (|nrm_hit);
  assign irq_fast = master_q[1] & (|fst_hit);

  always_comb begin
    clr_vec = '0;
    if (wr_en && in_win && fam == 4'hB)
      for (int b = 0; b < NB; b++)
        if (int'(bank) == b) clr_vec[b*32 +: 32] = wdata;
  end

  always_comb begin
    pend_num = '1;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (nrm_hit[i]) pend_num = 32'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      sel_q <= '0; en_q <= '0; typ_q <= '0; pol_q <= '0;
      swi_q <= '0; latch_q <= '0; master_q <= '0;
    end else begin
      s1 <= lines_in;
      s2 <= s1;
      s3 <= s2;
      latch_q <= ((latch_q & ~clr_vec) | edge_hit) & typ_q;
      if (wr_en && in_win) begin
        if (fam == 4'h6 && bank == 2'd1) master_q <= wdata[1:0];
        for (int b = 0; b < NB; b++) begin
          if (int'(bank) == b) begin
            case (fam)
              4'h0: sel_q[b*32 +: 32] <= wdata;
              4'h1: en_q[b*32 +: 32]  <= wdata;
              4'h2: en_q[b*32 +: 32]  <= en_q[b*32 +: 32] & ~wdata;
              4'h3: en_q[b*32 +: 32]  <= en_q[b*32 +: 32] | wdata;
              4'h4: typ_q[b*32 +: 32] <= wdata;
              4'h5: pol_q[b*32 +: 32] <= wdata;
              4'hC: swi_q[b*32 +: 32] <= wdata;
              default: ;
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (in_win) begin
      for (int b = 0; b < NB; b++) begin
        if (int'(bank) == b) begin
          case (fam)
            4'h0: rdata = sel_q[b*32 +: 32];
            4'h1: rdata = en_q[b*32 +: 32];
            4'h4: rdata = typ_q[b*32 +: 32];
            4'h5: rdata = pol_q[b*32 +: 32];
            4'hA: rdata = pend[b*32 +: 32];
            4'hC: rdata = swi_q[b*32 +: 32];
            default: ;
          endcase
        end
      end
      if (fam == 4'h6 && bank == 2'd1) rdata = {30'd0, master_q};
      if (fam == 4'hD && bank == 2'd0) rdata = pend_num;
    end
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [31:0]          wdata,
  input logic [NUM_LINES-1:0] en_q,
  input logic [NUM_LINES-1:0] latch_q,
  input logic [1:0]           master_q,
  input logic [31:0]          pend_num,
  input logic                 irq_norm,
  input logic                 irq_fast
);
  p_norm_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm |-> master_q[0]);

  p_fast_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |-> master_q[1]);

  p_enset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'('h30)) |=> ((en_q[31:0] & $past(wdata)) == $past(wdata)));

  p_enclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'('h20)) |=> ((en_q[31:0] & $past(wdata)) == 32'd0));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (($past(latch_q) & ~latch_q) == '0));

  p_none_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (master_q[0] && !irq_norm) |-> (pend_num == 32'hFFFF_FFFF));
endmodule

bind irq_hub irq_hub_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .en_q(en_q), .latch_q(latch_q), .master_q(master_q), .pend_num(pend_num),
  .irq_norm(irq_norm), .irq_fast(irq_fast)
);

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] lines = '0;
  logic        wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_norm, irq_fast;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  irq_hub #(.NUM_LINES(64), .ADDR_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .lines_in(lines), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_norm(irq_norm), .irq_fast(irq_fast));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    chk("R11 norm low", {31'd0, irq_norm}, 0);
    chk("R11 fast low", {31'd0, irq_fast}, 0);
    rd(12'h010, r); chk("R11 enable zero", r, 0);
    rd(12'h0A4, r); chk("R11 raw zero", r, 0);
    rd(12'h0D0, r); chk("R10 none pending", r, 32'hFFFF_FFFF);
    wr(12'h070, 32'hFFFF_FFFF);
    rd(12'h070, r); chk("R11 unmapped 0x70", r, 0);
    rd(12'h310, r); chk("R11 unmapped high", r, 0);
  endtask

  task automatic t_bank;
    logic [31:0] r;
    wr(12'h014, 32'hA5A5_0000);
    rd(12'h014, r); chk("R1 bank1 enable", r, 32'hA5A5_0000);
    rd(12'h010, r); chk("R1 bank0 untouched", r, 0);
    wr(12'h010, 32'h1234_5678);
    rd(12'h010, r); chk("R1 bank0 enable", r, 32'h1234_5678);
    rd(12'h014, r); chk("R1 bank1 kept", r, 32'hA5A5_0000);
    wr(12'h010, 0); wr(12'h014, 0);
  endtask

  task automatic t_setclr;
    logic [31:0] r;
    wr(12'h010, 32'h0000_00F0);
    wr(12'h030, 32'h0000_0003);
    rd(12'h010, r); chk("R2 set", r, 32'h0000_00F3);
    wr(12'h020, 32'h0000_0030);
    rd(12'h010, r); chk("R2 clear", r, 32'h0000_00C3);
    wr(12'h030, 0); wr(12'h020, 0);
    rd(12'h010, r); chk("R2 zero bits", r, 32'h0000_00C3);
    wr(12'h010, 0);
  endtask

  task automatic t_level;
    logic [31:0] r;
    @(negedge clk); lines[3] = 1;
    @(negedge clk); rd(12'h0A0, r); chk("R3 one clock", r & 32'h8, 0);
    @(negedge clk); rd(12'h0A0, r); chk("R3 two clocks", r & 32'h8, 32'h8);
    wr(12'h050, 32'h8);
    rd(12'h0A0, r); chk("R3 active-low idle", r & 32'h8, 0);
    @(negedge clk); lines[3] = 0;
    idle(3);
    rd(12'h0A0, r); chk("R3 active-low asserted", r & 32'h8, 32'h8);
    wr(12'h050, 0);
    rd(12'h0A0, r); chk("R3 back high", r & 32'h8, 0);
  endtask

  task automatic t_edge;
    logic [31:0] r;
    wr(12'h044, 32'h100);
    @(negedge clk); lines[40] = 1;
    idle(4);
    rd(12'h0A4, r); chk("R4 rising sets", r & 32'h100, 32'h100);
    lines[40] = 0;
    idle(4);
    rd(12'h0A4, r); chk("R4 sticky", r & 32'h100, 32'h100);
    wr(12'h0B4, 0);
    rd(12'h0A4, r); chk("R4 zero clear", r & 32'h100, 32'h100);
    wr(12'h0B4, 32'h100);
    rd(12'h0A4, r); chk("R4 cleared", r & 32'h100, 0);
    wr(12'h054, 32'h100);
    @(negedge clk); lines[40] = 1;
    idle(4);
    rd(12'h0A4, r); chk("R4 rising ignored when falling", r & 32'h100, 0);
    lines[40] = 0;
    idle(4);
    rd(12'h0A4, r); chk("R4 falling sets", r & 32'h100, 32'h100);
    wr(12'h0B4, 32'h100);
    rd(12'h0A4, r); chk("R4 falling cleared", r & 32'h100, 0);
    wr(12'h054, 0);
    @(negedge clk); lines[3] = 1;
    idle(3);
    wr(12'h0B0, 32'h8);
    rd(12'h0A0, r); chk("R4 clear on level ignored", r & 32'h8, 32'h8);
    lines[3] = 0;
    idle(3);
  endtask

  task automatic t_same;
    logic [31:0] r;
    wr(12'h044, 32'h300);
    @(negedge clk); lines[41] = 1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1; addr = 12'h0B4; wdata = 32'h200;
    @(negedge clk);
    wr_en = 0;
    rd(12'h0A4, r); chk("R5 edge beats clear", r & 32'h200, 32'h200);
    wr(12'h0B4, 32'h200);
    rd(12'h0A4, r); chk("R5 later clear", r & 32'h200, 0);
    lines[41] = 0;
    wr(12'h044, 0);
    idle(3);
  endtask

  task automatic t_route;
    logic [31:0] r;
    wr(12'h064, 3);
    rd(12'h064, r); chk("R7 master readback", r, 3);
    wr(12'h010, 32'h8);
    @(negedge clk); lines[3] = 1;
    idle(3);
    chk("R6 normal high", {31'd0, irq_norm}, 1);
    chk("R6 fast low", {31'd0, irq_fast}, 0);
    wr(12'h000, 32'h8);
    chk("R6 routed fast", {30'd0, irq_fast, irq_norm}, 2'b10);
    wr(12'h064, 1);
    chk("R7 fast gated", {30'd0, irq_fast, irq_norm}, 0);
    wr(12'h064, 2);
    chk("R7 fast only", {30'd0, irq_fast, irq_norm}, 2'b10);
    wr(12'h000, 0);
    chk("R7 normal gated", {30'd0, irq_fast, irq_norm}, 0);
    wr(12'h064, 3);
    chk("R7 normal back", {30'd0, irq_fast, irq_norm}, 2'b01);
    wr(12'h010, 0);
    chk("R6 disabled low", {31'd0, irq_norm}, 0);
    rd(12'h0A0, r); chk("R8 raw unmasked", r & 32'h8, 32'h8);
    lines[3] = 0;
    idle(3);
  endtask

  task automatic t_swi;
    logic [31:0] r;
    wr(12'h0C4, 32'h4);
    rd(12'h0A4, r); chk("R9 soft pending", r, 32'h4);
    rd(12'h0C4, r); chk("R9 readback", r, 32'h4);
    chk("R9 not enabled", {31'd0, irq_norm}, 0);
    wr(12'h014, 32'h4);
    chk("R9 soft drives", {31'd0, irq_norm}, 1);
    wr(12'h0C4, 0);
    rd(12'h0A4, r); chk("R9 removed", r, 0);
    chk("R9 output low", {31'd0, irq_norm}, 0);
    wr(12'h014, 0);
  endtask

  task automatic t_num;
    logic [31:0] r;
    wr(12'h0C0, 32'h0010_0080);
    rd(12'h0D0, r); chk("R10 disabled none", r, 32'hFFFF_FFFF);
    wr(12'h010, 32'h0010_0080);
    rd(12'h0D0, r); chk("R10 lowest", r, 7);
    wr(12'h000, 32'h80);
    rd(12'h0D0, r); chk("R10 fast skipped", r, 20);
    wr(12'h020, 32'h0010_0000);
    rd(12'h0D0, r); chk("R10 only fast", r, 32'hFFFF_FFFF);
    wr(12'h0C4, 32'h20); wr(12'h014, 32'h20);
    rd(12'h0D0, r); chk("R10 bank1 line", r, 37);
    wr(12'h0C0, 0); wr(12'h0C4, 0); wr(12'h010, 0); wr(12'h014, 0); wr(12'h000, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_bank();
    t_setclr();
    t_level();
    t_edge();
    t_same();
    t_route();
    t_swi();
    t_num();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule